// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Encoder with Scrambler

This block sits in the transmit path of a 100 Mbps twisted-pair PHY. Once per nibble clock it takes the 4-bit transmit data bus, the transmit-enable and transmit-error controls, and produces one scrambled 5-bit code group. A serialiser takes that code group next.

A frame opens with a start-of-stream delimiter pair in place of the first two preamble nibbles. Every later nibble is mapped to its 5-bit data code group. When transmit-enable drops, the block closes the frame with an end-of-stream delimiter pair and then sends idle code groups.

While a frame is active, an asserted transmit-error replaces that cycle's symbol with an invalid code group. The whole symbol stream, idle included, is XORed with a free-running 11-bit LFSR keystream. This stops repeated patterns from concentrating spectral energy.

Top module: `fx_tx_encoder`

## Requirements
- R1: While rst_ni is low, code_o is 5'b00000 and the keystream generator is loaded with the SEED parameter (default 11'h7FF).
- R2: Outside a frame and outside the closing delimiter pair, the unscrambled symbol is IDLE = 5'b11111.
- R3: Starting a frame requires tx_en_i high in a cycle where the encoder is idle. In that cycle the unscrambled symbol is J = 5'b11000. In the next cycle, if tx_en_i is still high, the symbol is K = 5'b10001. The nibbles offered in those two cycles are discarded.
- R4: After J and K, each cycle with tx_en_i high maps txd_i to a data code group, written as nibble:code. The mapping is 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R5: In any cycle with tx_en_i and tx_er_i both high (other than a cycle sending R), the unscrambled symbol is H = 5'b00100. This applies whether the slot would have carried J, K or data. The frame state still advances as it would without the error.
- R6: In the first cycle with tx_en_i low after a frame has started (after J, K or data), the symbol is T = 5'b01101. The next symbol is R = 5'b00111, followed by IDLE. If tx_en_i is high while R is sent, it is ignored in that cycle, so J follows one cycle later.
- R7: Each code_o bit is the symbol bit XORed with a keystream bit from an 11-bit LFSR for x^11 + x^9 + 1. For each step the feedback is s[10]^s[8], the state becomes {s[9:0], feedback}, and the feedback is the keystream bit. Five steps are taken per cycle, every cycle after reset. Step k (0..4) covers symbol bit 4-k, most significant bit first.
- R8: A receiver LFSR seeded with SEED and stepped in lockstep recovers every unscrambled symbol by XORing code_o with its own keystream.
- R9: code_o is registered. The symbol for the inputs sampled at a rising edge appears on code_o just after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Nibble clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 4 | Transmit data nibble |
| tx_en_i | input | 1 | Transmit enable, frames the data |
| tx_er_i | input | 1 | Transmit error request |
| code_o | output | 5 | Scrambled code group, bit 4 sent first |

## Verification
The bench drives random frames with random preamble lengths, payloads, gaps and sparse error cycles. On their own, these show that delimiters, data mapping and idle fill interlock correctly across frames.

A directed sweep walks all sixteen nibbles, which separates a single wrong table entry from a keystream fault. Further directed cases cover:
- a one-cycle frame, to tell apart closing after J and closing after data;
- an error on the J slot;
- transmit-enable rising during R, which shows whether a new frame can clip the closing delimiter.

Descrambling with a bench-side LFSR checks that the keystream phase is kept across idle periods.

// File: rtl/fx_tx_pkg.sv
package fx_tx_pkg;
  localparam int unsigned SYM_W = 5;
  localparam int unsigned NIB_W = 4;

  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t CG_IDLE = 5'b11111;
  localparam sym_t CG_J    = 5'b11000;
  localparam sym_t CG_K    = 5'b10001;
  localparam sym_t CG_T    = 5'b01101;
  localparam sym_t CG_R    = 5'b00111;
  localparam sym_t CG_H    = 5'b00100;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_K,
    FR_DATA,
    FR_R
  } fr_state_e;

  function automatic sym_t map_nibble(input logic [NIB_W-1:0] nib);
    sym_t s;
    case (nib)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/fx_tx_framer.sv
module fx_tx_framer
  import fx_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  output sym_t             sym_o
);
  fr_state_e state_q, state_d;
  sym_t      sym_base;

  always_comb begin
    state_d  = state_q;
    sym_base = CG_IDLE;
    unique case (state_q)
      FR_IDLE: begin
        if (tx_en_i) begin
          sym_base = CG_J;
          state_d  = FR_K;
        end
      end
      FR_K: begin
        if (tx_en_i) begin
          sym_base = CG_K;
          state_d  = FR_DATA;
        end else begin
          sym_base = CG_T;
          state_d  = FR_R;
        end
      end
      FR_DATA: begin
        if (tx_en_i) begin
          sym_base = map_nibble(txd_i);
        end else begin
          sym_base = CG_T;
          state_d  = FR_R;
        end
      end
      default: begin
        sym_base = CG_R;
        state_d  = FR_IDLE;
      end
    endcase
  end

  // error injection wins over any in-frame symbol, never over R
  assign sym_o = (tx_en_i && tx_er_i && state_q != FR_R) ? CG_H : sym_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FR_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/fx_tx_scrambler.sv
module fx_tx_scrambler
  import fx_tx_pkg::*;
#(
  parameter int unsigned LFSR_W = 11,
  parameter int unsigned TAP    = 9,
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  sym_t sym_i,
  output sym_t ks_o,
  output sym_t code_o
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  sym_t              ks;
  sym_t              code_q;

  always_comb begin
    logic [LFSR_W-1:0] s;
    logic              fb;
    s  = lfsr_q;
    ks = '0;
    for (int k = 0; k < int'(SYM_W); k++) begin
      fb = s[LFSR_W-1] ^ s[TAP-1];
      ks[SYM_W-1-k] = fb;
      s = {s[LFSR_W-2:0], fb};
    end
    lfsr_d = s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= SEED;
      code_q <= '0;
    end else begin
      lfsr_q <= lfsr_d;
      code_q <= sym_i ^ ks;
    end
  end

  assign ks_o   = ks;
  assign code_o = code_q;
endmodule

// File: rtl/fx_tx_encoder.sv
module fx_tx_encoder
  import fx_tx_pkg::*;
#(
  parameter int unsigned LFSR_W = 11,
  parameter int unsigned TAP    = 9,
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] txd_i,
  input  logic       tx_en_i,
  input  logic       tx_er_i,
  output logic [4:0] code_o
);
  sym_t sym_w;
  sym_t ks_w;

  fx_tx_framer i_framer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .txd_i   (txd_i),
    .tx_en_i (tx_en_i),
    .tx_er_i (tx_er_i),
    .sym_o   (sym_w)
  );

  fx_tx_scrambler #(
    .LFSR_W (LFSR_W),
    .TAP    (TAP),
    .SEED   (SEED)
  ) i_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sym_i  (sym_w),
    .ks_o   (ks_w),
    .code_o (code_o)
  );
endmodule

// File: rtl/fx_tx_encoder_chk.sv
module fx_tx_encoder_chk
  import fx_tx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic       tx_er_i,
  input logic [4:0] sym_i,
  input logic [4:0] ks_i,
  input logic [4:0] code_o
);
  // R5
  err_inject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && tx_er_i && sym_i != CG_R) |-> sym_i == CG_H);

  // R3
  j_then_k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_i == CG_J |=> (sym_i == CG_K || sym_i == CG_H || sym_i == CG_T));

  // R6
  t_then_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_i == CG_T |=> sym_i == CG_R);

  // R6
  r_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_i == CG_R |=> (sym_i == CG_IDLE || sym_i == CG_J || sym_i == CG_H));

  // R2
  idle_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && sym_i != CG_T && sym_i != CG_R) |-> sym_i == CG_IDLE);

  // R9
  one_cycle_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (code_o ^ $past(ks_i)) == $past(sym_i));
endmodule

bind fx_tx_encoder fx_tx_encoder_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tx_en_i (tx_en_i),
  .tx_er_i (tx_er_i),
  .sym_i   (sym_w),
  .ks_i    (ks_w),
  .code_o  (code_o)
);

// File: tb/test_fx_tx_encoder.sv
module test_fx_tx_encoder;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] txd = '0;
  logic       en = 1'b0;
  logic       er = 1'b0;
  logic [4:0] code;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int         m_state = 0;  // 0 idle, 1 K, 2 data, 3 R
  logic [10:0] m_lfsr = 11'h7FF;

  always #10 clk = ~clk;

  fx_tx_encoder i_fx_tx_encoder (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .txd_i   (txd),
    .tx_en_i (en),
    .tx_er_i (er),
    .code_o  (code)
  );

  function automatic logic [4:0] ref_map(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one nibble cycle: drive at negedge, model at posedge, check at next negedge
  task automatic step(input logic e, input logic r, input logic [3:0] d);
    logic [4:0] plain, ks;
    string      tag;
    en = e; er = r; txd = d;
    @(posedge clk);
    tag = "R2";
    case (m_state)
      0: if (e) begin plain = 5'b11000; m_state = 1; tag = "R3"; end
         else plain = 5'b11111;
      1: if (e) begin plain = 5'b10001; m_state = 2; tag = "R3"; end
         else begin plain = 5'b01101; m_state = 3; tag = "R6"; end
      2: if (e) begin plain = ref_map(d); tag = "R4"; end
         else begin plain = 5'b01101; m_state = 3; tag = "R6"; end
      default: begin plain = 5'b00111; m_state = 0; tag = "R6"; end
    endcase
    if (e && r && plain != 5'b00111) begin plain = 5'b00100; tag = "R5"; end
    for (int k = 0; k < 5; k++) begin
      logic fb;
      fb = m_lfsr[10] ^ m_lfsr[8];
      ks[4-k] = fb;
      m_lfsr = {m_lfsr[9:0], fb};
    end
    @(negedge clk);
    check({tag, " R7 R9 code"}, code, plain ^ ks);
    check("R8 descrambled", code ^ ks, plain);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED_1234);
    #35;
    check("R1 reset", code, 5'b00000);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 idle, R7 keystream from seed
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 4'h0);

    // R4 full table sweep
    step(1'b1, 1'b0, 4'h5);
    step(1'b1, 1'b0, 4'h5);
    for (int n = 0; n < 16; n++) step(1'b1, 1'b0, 4'(n));
    step(1'b0, 1'b0, 4'h0);
    step(1'b0, 1'b0, 4'h0);
    step(1'b0, 1'b0, 4'h0);

    // R6 one-cycle frame: J then T
    step(1'b1, 1'b0, 4'h5);
    step(1'b0, 1'b0, 4'h0);
    // R6 enable during R delays J
    step(1'b1, 1'b0, 4'h5);
    step(1'b1, 1'b0, 4'h5);
    step(1'b1, 1'b0, 4'h5);
    step(1'b1, 1'b0, 4'hD);
    step(1'b0, 1'b0, 4'h0);
    step(1'b0, 1'b0, 4'h0);
    step(1'b0, 1'b0, 4'h0);

    // R5 error on J slot, then data errors
    step(1'b1, 1'b1, 4'h5);
    step(1'b1, 1'b0, 4'h5);
    step(1'b1, 1'b1, 4'h3);
    step(1'b1, 1'b0, 4'h3);
    step(1'b0, 1'b1, 4'h0);  // er without en: no effect
    step(1'b0, 1'b1, 4'h0);
    step(1'b0, 1'b1, 4'h0);

    // random frames
    for (int f = 0; f < 300; f++) begin
      int pre, len, gap;
      pre = 2 + int'($urandom_range(0, 14));
      len = int'($urandom_range(0, 40));
      gap = int'($urandom_range(0, 6));
      for (int i = 0; i < pre; i++) step(1'b1, ($urandom_range(0, 31) == 0), 4'h5);
      for (int i = 0; i < len; i++)
        step(1'b1, ($urandom_range(0, 31) == 0), 4'($urandom_range(0, 15)));
      for (int i = 0; i < gap; i++) step(1'b0, $urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)));
    end
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule